// File: doc/BRIEF.md
# Isolated Bus Repeater Side-B Pulse-Stretch Controller

This block is the digital control for the side-B half of a bidirectional open-drain bus repeater. The two sides are joined by two slow, one-way links, one in each direction. A comparator tells the block when an external device pulls side B low. The comparator senses at a threshold that the block's own pull-down cannot reach, so the block never hears itself. The block also receives the returned link signal, which shows whether side A is low.

Both inputs are asynchronous, so each passes through a flop synchronizer. The side-B input then goes through a run-length deglitch filter. A filtered assertion drives the outgoing link. On the filter's rising edge the block also sets a stored bit, and that bit holds the outgoing link asserted until the returned link confirms that side A went low. Short pulses are therefore stretched to the round-trip time of the links. The block pulls side B low while the stored bit is set or while the returned link is asserted. Side B thus follows assertions that start on side A, and it stays low until a release has made the full trip around the loop.

Top module: `bus_b_repeater_ctl`

## Requirements
- R1: After reset, `fwd_link_o` and `b_pulldown_o` are both 0.
- R2: If `b_pulled_low_i` is 1 for fewer than FILT_LEN consecutive synchronized samples, the pulse is dropped. `fwd_link_o` and `b_pulldown_o` stay 0.
- R3: If `b_pulled_low_i` is held 1 for L clock cycles, with L at least FILT_LEN and L longer than the link round trip, `fwd_link_o` is 1 for exactly L-FILT_LEN+1 cycles. The stored bit adds no stretch in this case.
- R4: On the rising edge of the filtered input, with the returned link at 0, the stored bit is set. `fwd_link_o` then stays 1 after a short input ends, until the returned link rises. The stretch lasts between the link round trip and the round trip plus 6 cycles.
- R5: The stored bit is cleared only by a rising edge of the synchronized `ret_link_i`. `fwd_link_o` falls only after the filtered input or that edge has ended its assertion.
- R6: While the stored bit is set, `fwd_link_o` and `b_pulldown_o` are both 1.
- R7: An assertion that starts on side A (`ret_link_i` = 1) makes `b_pulldown_o` follow it for the same length: the A-side low time, within 1 cycle. `fwd_link_o` stays 0, so the block's own drive is never echoed back.
- R8: If side A is already asserted when a side-B assertion passes the filter, the stored bit is not set. Once both sides release, both outputs return to 0, so the bus does not latch low.
- R9: For every side-B pulse that passes the filter and lasts at least FILT_LEN+3 cycles, side A and side B each see exactly one falling edge and one rising edge.
- R10: For a stretched short pulse, `b_pulldown_o` stays 1 for at least the sum of both link turn-on delays, the B-to-A turn-off delay, the side-A rise delay and the A-to-B turn-off delay, and for at most 10 cycles more than that sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| b_pulled_low_i | input | 1 | Comparator output; 1 when an external device holds side B low (asynchronous) |
| ret_link_i | input | 1 | Returned A-to-B link; 1 when side A is low (asynchronous) |
| fwd_link_o | output | 1 | B-to-A link drive; 1 asserts side A low |
| b_pulldown_o | output | 1 | Side-B open-drain pull-down enable |

## Verification
A side-B input that becomes 1 before rising edge 0 shows up on `fwd_link_o` after rising edge FILT_LEN+1, because the synchronizer and the run counter come first. The stored bit, and with it the self-drive on `b_pulldown_o`, follows one edge later. The returned link needs two more edges through its synchronizer and one more to clear the stored bit. The bench drives its inputs and its link models on falling edges, and it measures durations by counting the falling edges at which an output is high. Each scenario waits a fixed idle window, longer than the full loop, before it compares edge counts and durations. The exact lengths checked are the long-pulse forward time and the side-A follow time. The stretch and the minimum low time are checked against windows that allow for the synchronizer latency.

// File: rtl/repeater_pkg.sv
`timescale 1ns/1ps
package repeater_pkg;

    // State of the stretch core: stored assertion bit and edge-detect history.
    typedef struct packed {
        logic stk;
        logic filt_prev;
        logic ret_prev;
    } core_state_t;

    localparam core_state_t CORE_IDLE = '0;

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/rep_sync.sv
`timescale 1ns/1ps
module rep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int NS = (STAGES < 2) ? 2 : STAGES;

    logic [NS-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[NS-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign q_o = sr_q[NS-1];
endmodule

// File: rtl/rep_deglitch.sv
`timescale 1ns/1ps
module rep_deglitch #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    output logic filt_o
);
    import repeater_pkg::*;

    localparam int             CW  = cnt_width(FILT_LEN);
    localparam logic [CW-1:0]  LIM = CW'(FILT_LEN);

    typedef struct packed {
        logic [CW-1:0] run;
    } flt_state_t;

    flt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!in_i)               st_d.run = '0;
        else if (st_q.run != LIM) st_d.run = st_q.run + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt_o = (st_q.run == LIM);
endmodule

// File: rtl/rep_stretch_core.sv
`timescale 1ns/1ps
module rep_stretch_core (
    input  logic clk,
    input  logic rst_n,
    input  logic filt_i,
    input  logic ret_i,
    output logic stk_o,
    output logic ret_prev_o,
    output logic fwd_o,
    output logic pd_o
);
    import repeater_pkg::*;

    core_state_t st_d, st_q;
    logic        filt_rise, ret_rise;

    always_comb begin
        filt_rise      = filt_i & ~st_q.filt_prev;
        ret_rise       = ret_i & ~st_q.ret_prev;
        st_d           = st_q;
        st_d.filt_prev = filt_i;
        st_d.ret_prev  = ret_i;
        // Set only when the far side is idle; a confirming edge always clears.
        st_d.stk       = (filt_rise & ~ret_i) | (st_q.stk & ~ret_rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CORE_IDLE;
        else        st_q <= st_d;
    end

    assign stk_o      = st_q.stk;
    assign ret_prev_o = st_q.ret_prev;
    assign fwd_o      = filt_i | st_q.stk;
    assign pd_o       = st_q.stk | ret_i;
endmodule

// File: rtl/bus_b_repeater_ctl.sv
`timescale 1ns/1ps
module bus_b_repeater_ctl #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic b_pulled_low_i,
    input  logic ret_link_i,
    output logic fwd_link_o,
    output logic b_pulldown_o
);
    logic cmp_sync;
    logic ret_sync;
    logic filt;
    logic stk_q;
    logic ret_prev_q;

    rep_sync #(.STAGES(SYNC_STAGES)) i_sync_b (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (b_pulled_low_i),
        .q_o   (cmp_sync)
    );

    rep_sync #(.STAGES(SYNC_STAGES)) i_sync_ret (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ret_link_i),
        .q_o   (ret_sync)
    );

    rep_deglitch #(.FILT_LEN(FILT_LEN)) i_flt (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_i   (cmp_sync),
        .filt_o (filt)
    );

    rep_stretch_core i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .filt_i     (filt),
        .ret_i      (ret_sync),
        .stk_o      (stk_q),
        .ret_prev_o (ret_prev_q),
        .fwd_o      (fwd_link_o),
        .pd_o       (b_pulldown_o)
    );
endmodule

// File: rtl/bus_b_repeater_ctl_chk.sv
`timescale 1ns/1ps
module bus_b_repeater_ctl_chk #(
    parameter int FILT_LEN = 4
) (
    input logic clk,
    input logic rst_n,
    input logic cmp_s,
    input logic ret_s,
    input logic ret_prev,
    input logic stk,
    input logic fwd,
    input logic pd
);
    // Independent run-length count of the synchronized side-B input.
    logic [15:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              run_q <= '0;
        else if (!cmp_s)         run_q <= '0;
        else if (run_q != '1)    run_q <= run_q + 1'b1;
    end

    assert_fwd_needs_filter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fwd) |-> (run_q >= 16'(FILT_LEN)));

    assert_clear_on_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stk) |-> $past(ret_s && !ret_prev));

    assert_fwd_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fwd) |-> ($past(!cmp_s) || $past(ret_s && !ret_prev)));

    assert_set_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stk) |-> $past(!ret_s));

    assert_stretch_selfdrive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stk |-> (fwd && pd));
endmodule

bind bus_b_repeater_ctl bus_b_repeater_ctl_chk #(.FILT_LEN(FILT_LEN)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_s    (cmp_sync),
    .ret_s    (ret_sync),
    .ret_prev (ret_prev_q),
    .stk      (stk_q),
    .fwd      (fwd_link_o),
    .pd       (b_pulldown_o)
);

// File: tb/test_bus_b_repeater_ctl.sv
`timescale 1ns/1ps
module test_bus_b_repeater_ctl;
    localparam int FILT_LEN = 4;
    localparam int D_BA     = 6;
    localparam int D_AB     = 5;
    localparam int RC       = 3;
    localparam int LOOP     = D_BA + D_AB;
    localparam int MIN_LOW  = D_BA + D_AB + D_BA + RC + D_AB;
    localparam int IDLE     = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic b_ext = 1'b0;
    logic a_ext = 1'b0;
    logic fwd, pd, ret;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    bus_b_repeater_ctl #(.SYNC_STAGES(2), .FILT_LEN(FILT_LEN)) i_bus_b_repeater_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .b_pulled_low_i (b_ext),
        .ret_link_i     (ret),
        .fwd_link_o     (fwd),
        .b_pulldown_o   (pd)
    );

    // Link and side-A models, advanced on falling edges.
    logic [D_BA-1:0] ba_sr = '0;
    logic [D_AB-1:0] ab_sr = '0;
    int   rc_cnt = 0;
    logic a_low_raw, a_line_low, b_line_low;

    assign a_low_raw  = ba_sr[D_BA-1] | a_ext;
    assign a_line_low = a_low_raw | (rc_cnt != 0);
    assign ret        = ab_sr[D_AB-1];
    assign b_line_low = b_ext | (pd === 1'b1);

    always @(negedge clk) begin
        ba_sr <= {ba_sr[D_BA-2:0], (fwd === 1'b1)};
        ab_sr <= {ab_sr[D_AB-2:0], a_line_low};
        if (a_low_raw)        rc_cnt <= RC;
        else if (rc_cnt != 0) rc_cnt <= rc_cnt - 1;
    end

    // Meters.
    int fwd_hi = 0, pd_hi = 0;
    int a_fall = 0, a_rise = 0, b_fall = 0, b_rise = 0;

    always @(negedge clk) begin
        if (fwd === 1'b1) fwd_hi <= fwd_hi + 1;
        if (pd === 1'b1)  pd_hi  <= pd_hi + 1;
    end
    always @(posedge a_line_low) a_fall = a_fall + 1;
    always @(negedge a_line_low) a_rise = a_rise + 1;
    always @(posedge b_line_low) b_fall = b_fall + 1;
    always @(negedge b_line_low) b_rise = b_rise + 1;

    task automatic clear_meters();
        @(negedge clk);
        fwd_hi = 0; pd_hi = 0;
        a_fall = 0; a_rise = 0; b_fall = 0; b_rise = 0;
    endtask

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic drive_b(input int len);
        @(negedge clk) b_ext = 1'b1;
        repeat (len) @(negedge clk);
        b_ext = 1'b0;
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk(fwd === 1'b0, "R1 fwd after reset", int'(fwd), 0);
        chk(pd === 1'b0, "R1 pulldown after reset", int'(pd), 0);
    endtask

    task automatic test_dropped();
        clear_meters();
        drive_b(FILT_LEN - 1);
        repeat (IDLE) @(negedge clk);
        chk(fwd_hi == 0, "R2 short pulse fwd cycles", fwd_hi, 0);
        chk(pd_hi == 0, "R2 short pulse pulldown cycles", pd_hi, 0);
        chk(a_fall == 0, "R2 short pulse side A edges", a_fall, 0);
    endtask

    task automatic test_stretch();
        clear_meters();
        drive_b(FILT_LEN + 3);
        repeat (IDLE) @(negedge clk);
        chk(fwd_hi >= LOOP && fwd_hi <= LOOP + 6, "R4 stretched fwd cycles", fwd_hi, LOOP);
        chk(pd_hi >= MIN_LOW && pd_hi <= MIN_LOW + 10, "R10 min side-B low", pd_hi, MIN_LOW);
        chk(a_fall == 1 && a_rise == 1, "R9 stretch side A edges", a_fall + a_rise, 2);
        chk(b_fall == 1 && b_rise == 1, "R9 stretch side B edges", b_fall + b_rise, 2);
        chk(fwd === 1'b0 && pd === 1'b0, "R5 released after confirm", int'(fwd) + int'(pd), 0);
    endtask

    task automatic test_near_loop();
        clear_meters();
        drive_b(LOOP + 4);
        repeat (IDLE) @(negedge clk);
        chk(a_fall == 1 && a_rise == 1, "R9 near-loop side A edges", a_fall + a_rise, 2);
        chk(b_fall == 1 && b_rise == 1, "R9 near-loop side B edges (no double pulse)", b_fall + b_rise, 2);
        chk(pd_hi >= MIN_LOW, "R10 near-loop side-B low", pd_hi, MIN_LOW);
    endtask

    task automatic test_long();
        clear_meters();
        drive_b(60);
        repeat (IDLE) @(negedge clk);
        chk(fwd_hi == 60 - FILT_LEN + 1, "R3 long pulse fwd cycles", fwd_hi, 60 - FILT_LEN + 1);
        chk(a_fall == 1 && a_rise == 1, "R9 long side A edges", a_fall + a_rise, 2);
        chk(b_fall == 1 && b_rise == 1, "R9 long side B edges", b_fall + b_rise, 2);
    endtask

    task automatic test_side_a();
        clear_meters();
        @(negedge clk) a_ext = 1'b1;
        repeat (40) @(negedge clk);
        a_ext = 1'b0;
        repeat (IDLE) @(negedge clk);
        chk(fwd_hi == 0, "R7 no echo on fwd", fwd_hi, 0);
        chk(pd_hi >= 40 + RC - 1 && pd_hi <= 40 + RC + 1, "R7 pulldown follows side A", pd_hi, 40 + RC);
        chk(b_fall == 1 && b_rise == 1, "R7 side B edges", b_fall + b_rise, 2);
    endtask

    task automatic test_overlap();
        clear_meters();
        @(negedge clk) a_ext = 1'b1;
        repeat (20) @(negedge clk);
        drive_b(10);
        repeat (20) @(negedge clk);
        a_ext = 1'b0;
        repeat (IDLE) @(negedge clk);
        chk(fwd === 1'b0, "R8 fwd idle after overlap", int'(fwd), 0);
        chk(pd === 1'b0, "R8 pulldown idle after overlap", int'(pd), 0);
        chk(a_fall == 1 && a_rise == 1, "R8 overlap side A edges", a_fall + a_rise, 2);
        chk(b_fall == 1 && b_rise == 1, "R8 overlap side B edges", b_fall + b_rise, 2);
        chk(fwd_hi == 10 - FILT_LEN + 1, "R8 overlap fwd not stretched", fwd_hi, 10 - FILT_LEN + 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_dropped();
        test_stretch();
        test_near_loop();
        test_long();
        test_side_a();
        test_overlap();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule